// File: doc/BRIEF.md
# Interleaved Chroma Horizontal 4-Tap Interpolator

This block filters one row of chroma at a time, where the two colour components alternate byte by byte. Each output byte is a weighted sum of four input bytes of the same component. Those bytes sit two positions apart in the row. The sum is rounded, shifted down by six and clamped to an unsigned byte.

Rows arrive as a byte-per-cycle valid/ready stream, and outputs leave as a byte stream with the same handshake. Back-pressure works as follows:
- A byte is transferred on any rising edge where both valid and ready are high.
- While `out_ready` is low and `out_valid` is high, the output byte and its markers are held.
- While the output is held, the whole pipeline freezes and `in_ready` drops.
- `in_ready` is a combinational function of `out_ready` and the block's own state.

A block is started with a plain command pulse that carries the per-component width and the row count. The four filter weights are loaded through a configuration strobe while the block is idle.

Top module: `chroma_hinterp`

## Requirements
- R1: Input row byte k (counted from 0 at `in_sor`) feeds the filter. Output byte j of a row uses input bytes j, j+2, j+4 and j+6 as taps 0..3. In the output's own indexing these are positions n-2, n, n+2 and n+4, so even and odd bytes are never mixed.
- R2: Each weight is used as its magnitude. The weights sit in `cfg_coef`, with tap i in bits [8i+7:8i]. The tap 0 and tap 3 products are subtracted and the tap 1 and tap 2 products are added, whatever the programmed signs.
- R3: The weighted sum is formed modulo 2^16. 32 is added, also modulo 2^16. The result is read as a signed 16-bit value and shifted right arithmetically by 6.
- R4: The shifted value is clamped: below 0 gives 0, above 255 gives 255, and any other value passes unchanged.
- R5: A row of per-component width wd carries 2*wd+6 input bytes, with `in_sor` on the first byte and `in_eor` on the last. It yields exactly 2*wd output bytes, with `out_sor` on the first and `out_eor` on the last.
- R6: `cmd_go` with a nonzero height ht, issued while idle, raises `busy` on the next cycle. The block then takes ht rows, and `busy` falls the cycle after the final input byte is accepted. `out_eob` is high only on the last output byte of the block. The command needs wd even and nonzero, and ht even when wd is 2.
- R7: A command with ht equal to 0 leaves `busy` and `in_ready` low and produces no output.
- R8: `cfg_valid` while idle latches new weights. `cfg_valid` while `busy` is high is ignored, and the block keeps its earlier weights.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the markers hold. No output byte is lost or repeated under any pattern of `out_ready`.
- R10: After reset, `busy`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Weight load strobe (honoured when idle) |
| cfg_coef | input | 32 | Four signed 8-bit weights, tap i in bits [8i+7:8i] |
| cmd_go | input | 1 | Block start pulse |
| cmd_wd | input | 8 | Per-component width of the block |
| cmd_ht | input | 8 | Number of rows in the block |
| busy | output | 1 | Block accepted and rows still expected |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Interleaved chroma input byte |
| in_sor | input | 1 | First byte of an input row |
| in_eor | input | 1 | Last byte of an input row |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Filtered output byte |
| out_sor | output | 1 | First output byte of a row |
| out_eor | output | 1 | Last output byte of a row |
| out_eob | output | 1 | Last output byte of the block |

## Verification
A wrong tap-window or position count shows up on the first output byte of a row, three cycles after the seventh input byte is accepted. It appears either as a wrong value or as a misplaced `out_sor`/`out_eor`. A wrong weight latch or sign pattern changes every affected byte of the next block at once. Constant-level rows pin the clamp and sign paths to exact values, and interleaved two-level rows expose any mixing of the components. A broken stall path shows up as a changed held byte or a missing byte within one output beat of the stall.

// File: rtl/chi_pkg.sv
package chi_pkg;
  localparam int DW      = 8;
  localparam int NTAPS   = 4;
  localparam int TAP_GAP = 2;
  localparam int WIN     = TAP_GAP * (NTAPS - 1);
  // taps whose product is subtracted from the sum
  localparam logic [NTAPS-1:0] TAP_SUB = 4'b1001;

  typedef logic [DW-1:0] pix_t;

  typedef struct packed {
    logic sor;
    logic eor;
    logic eob;
  } mark_t;
endpackage

// File: rtl/chi_coef_bank.sv
module chi_coef_bank
  import chi_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      cfg_valid,
  input  logic [NTAPS*CW-1:0]       cfg_coef,
  output logic [NTAPS-1:0][CW-1:0]  mag
);
  logic [NTAPS-1:0][CW-1:0] mag_next;

  always_comb begin
    for (int i = 0; i < NTAPS; i++) begin
      mag_next[i] = cfg_coef[i*CW+CW-1] ? (~cfg_coef[i*CW +: CW] + CW'(1))
                                        : cfg_coef[i*CW +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   mag <= '0;
    else if (cfg_valid && !busy)  mag <= mag_next;
  end

  // R8
  coef_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mag));
endmodule

// File: rtl/chi_row_seq.sv
module chi_row_seq
  import chi_pkg::*;
#(
  parameter int WD_W = 8,
  parameter int HT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_go,
  input  logic [WD_W-1:0]        cmd_wd,
  input  logic [HT_W-1:0]        cmd_ht,
  input  logic                   adv,
  input  logic                   in_valid,
  input  pix_t                   in_data,
  input  logic                   in_sor,
  input  logic                   in_eor,
  output logic                   in_ready,
  output logic                   busy,
  output logic                   emit,
  output pix_t [NTAPS-1:0]       taps,
  output mark_t                  mark
);
  localparam int MAX_ROW = 2 * ((1 << WD_W) - 1) + WIN + 1;
  localparam int POS_W   = $clog2(MAX_ROW);

  logic                    active;
  logic [WD_W-1:0]         wd_q;
  logic [HT_W-1:0]         rows_left;
  logic [POS_W-1:0]        pos;
  logic [POS_W-1:0]        last_pos;
  logic [WIN-1:0][DW-1:0]  win;
  logic [WIN:0][DW-1:0]    ext;
  logic                    fire;
  logic                    row_end;

  assign busy     = active;
  assign in_ready = active && adv;
  assign fire     = in_valid && in_ready;
  assign last_pos = POS_W'({wd_q, 1'b0}) + POS_W'(WIN - 1);
  assign row_end  = (pos == last_pos);
  assign ext      = {win, in_data};

  // tap i reaches back WIN - i*TAP_GAP bytes from the newest byte
  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    assign taps[i] = ext[WIN - i*TAP_GAP];
  end

  assign emit     = fire && (pos >= POS_W'(WIN));
  assign mark.sor = (pos == POS_W'(WIN));
  assign mark.eor = row_end;
  assign mark.eob = row_end && (rows_left == HT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      wd_q      <= '0;
      rows_left <= '0;
      pos       <= '0;
      win       <= '0;
    end else if (!active) begin
      if (cmd_go && cmd_ht != '0) begin
        active    <= 1'b1;
        wd_q      <= cmd_wd;
        rows_left <= cmd_ht;
        pos       <= '0;
      end
    end else if (fire) begin
      win <= {win[WIN-2:0], in_data};
      if (row_end) begin
        pos       <= '0;
        rows_left <= rows_left - HT_W'(1);
        if (rows_left == HT_W'(1)) active <= 1'b0;
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

  // R5
  sor_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (in_sor == (pos == '0)));
  // R5
  eor_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (in_eor == row_end));
  // R7
  zero_ht_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && cmd_go && cmd_ht == '0) |=> !busy);
  // R6
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && cmd_go && cmd_ht != '0) |->
      (cmd_wd != '0 && !cmd_wd[0] && (cmd_wd != WD_W'(2) || !cmd_ht[0])));
endmodule

// File: rtl/chi_mac.sv
module chi_mac
  import chi_pkg::*;
#(
  parameter int CW    = 8,
  parameter int ACC_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      in_vld,
  input  pix_t [NTAPS-1:0]          taps,
  input  mark_t                     mark,
  input  logic [NTAPS-1:0][CW-1:0]  mag,
  output logic                      sum_vld,
  output logic [ACC_W-1:0]          sum,
  output mark_t                     sum_mark
);
  logic                         a_vld;
  pix_t [NTAPS-1:0]             a_taps;
  mark_t                        a_mark;
  logic [NTAPS-1:0][ACC_W-1:0]  prod;
  logic [ACC_W-1:0]             acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_taps <= '0;
      a_mark <= '0;
    end else if (adv) begin
      a_vld  <= in_vld;
      a_taps <= taps;
      a_mark <= mark;
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_prod
    assign prod[i] = ACC_W'(mag[i]) * ACC_W'(a_taps[i]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (TAP_SUB[i]) acc = acc - prod[i];
      else            acc = acc + prod[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_vld  <= 1'b0;
      sum      <= '0;
      sum_mark <= '0;
    end else if (adv) begin
      sum_vld  <= a_vld;
      sum      <= acc;
      sum_mark <= a_mark;
    end
  end
endmodule

// File: rtl/chi_narrow.sv
module chi_narrow
  import chi_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ACC_W-1:0]  sum,
  input  mark_t             mark,
  input  logic              out_ready,
  output logic              adv,
  output logic              out_valid,
  output pix_t              out_data,
  output mark_t             out_mark
);
  localparam int RND  = 1 << (SHIFT - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic signed [ACC_W-1:0] rnd;
  logic signed [ACC_W-1:0] sh;
  pix_t                    val;

  assign adv = !out_valid || out_ready;

  always_comb begin
    rnd = $signed(sum + ACC_W'(RND));
    sh  = rnd >>> SHIFT;
    if (sh < 0)                         val = '0;
    else if (sh > $signed(ACC_W'(MAXV))) val = '1;
    else                                val = sh[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mark  <= '0;
    end else if (adv) begin
      out_valid <= in_vld;
      out_data  <= val;
      out_mark  <= mark;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mark)));
endmodule

// File: rtl/chroma_hinterp.sv
module chroma_hinterp
  import chi_pkg::*;
#(
  parameter int CW    = 8,
  parameter int ACC_W = 16,
  parameter int SHIFT = 6,
  parameter int WD_W  = 8,
  parameter int HT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic [NTAPS*CW-1:0]  cfg_coef,
  input  logic                 cmd_go,
  input  logic [WD_W-1:0]      cmd_wd,
  input  logic [HT_W-1:0]      cmd_ht,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_sor,
  input  logic                 in_eor,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_data,
  output logic                 out_sor,
  output logic                 out_eor,
  output logic                 out_eob
);
  logic                      adv;
  logic [NTAPS-1:0][CW-1:0]  mag;
  logic                      emit;
  pix_t [NTAPS-1:0]          taps;
  mark_t                     emit_mark;
  logic                      sum_vld;
  logic [ACC_W-1:0]          sum;
  mark_t                     sum_mark;
  mark_t                     o_mark;

  chi_coef_bank #(.CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cfg_valid(cfg_valid), .cfg_coef(cfg_coef), .mag(mag)
  );

  chi_row_seq #(.WD_W(WD_W), .HT_W(HT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_wd(cmd_wd), .cmd_ht(cmd_ht),
    .adv(adv), .in_valid(in_valid), .in_data(in_data), .in_sor(in_sor),
    .in_eor(in_eor), .in_ready(in_ready), .busy(busy), .emit(emit),
    .taps(taps), .mark(emit_mark)
  );

  chi_mac #(.CW(CW), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(emit), .taps(taps),
    .mark(emit_mark), .mag(mag), .sum_vld(sum_vld), .sum(sum), .sum_mark(sum_mark)
  );

  chi_narrow #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_narrow (
    .clk(clk), .rst_n(rst_n), .in_vld(sum_vld), .sum(sum), .mark(sum_mark),
    .out_ready(out_ready), .adv(adv), .out_valid(out_valid),
    .out_data(out_data), .out_mark(o_mark)
  );

  assign out_sor = o_mark.sor;
  assign out_eor = o_mark.eor;
  assign out_eob = o_mark.eob;

  // R6
  eob_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eob) |-> out_eor);
endmodule

// File: tb/chroma_hinterp_tb_top.sv
`timescale 1ns/1ps
module chroma_hinterp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [31:0] cfg_coef = '0;
  logic        cmd_go = 1'b0;
  logic [7:0]  cmd_wd = '0;
  logic [7:0]  cmd_ht = '0;
  logic        busy;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sor = 1'b0;
  logic        in_eor = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_sor, out_eor, out_eob;

  always #4 clk = ~clk;

  chroma_hinterp dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_coef(cfg_coef),
    .cmd_go(cmd_go), .cmd_wd(cmd_wd), .cmd_ht(cmd_ht), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sor(in_sor), .in_eor(in_eor), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sor(out_sor),
    .out_eor(out_eor), .out_eob(out_eob)
  );

  typedef struct {
    logic [7:0] d;
    logic [2:0] m;
  } exp_t;

  exp_t  exp_q[$];
  exp_t  e;
  string cur_req = "R10";
  int    n_chk = 0;
  int    n_fail = 0;
  int    cf[4];
  bit    stall_en = 1'b0;
  bit    hold_pend = 1'b0;
  logic [7:0] hold_d;
  logic [2:0] hold_m;

  task automatic check(string req, bit ok, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int model(int t0, int t1, int t2, int t3);
    int s;
    logic [15:0] w;
    int v;
    s = -((cf[0] < 0) ? -cf[0] : cf[0]) * t0
        + ((cf[1] < 0) ? -cf[1] : cf[1]) * t1
        + ((cf[2] < 0) ? -cf[2] : cf[2]) * t2
        - ((cf[3] < 0) ? -cf[3] : cf[3]) * t3;
    w = 16'(s + 32);
    v = int'($signed(w)) >>> 6;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // output monitor (R9 hold check plus value/marker compare)
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check("R9", out_valid === 1'b1 && out_data === hold_d &&
              {out_sor, out_eor, out_eob} === hold_m,
              "held byte changed", int'(out_data), int'(hold_d));
      end
      hold_pend = out_valid && !out_ready;
      hold_d    = out_data;
      hold_m    = {out_sor, out_eor, out_eob};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(cur_req, 1'b0, "unexpected output byte", int'(out_data), -1);
        end else begin
          e = exp_q.pop_front();
          check(cur_req, out_data === e.d, "output byte", int'(out_data), int'(e.d));
          check(cur_req, {out_sor, out_eor, out_eob} === e.m,
                "markers sor/eor/eob", int'({out_sor, out_eor, out_eob}), int'(e.m));
        end
      end
    end
  end

  task automatic load_cfg(int c0, int c1, int c2, int c3, bit update_model);
    cfg_coef  = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
    cfg_valid = 1'b1;
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    if (update_model) begin
      cf[0] = c0; cf[1] = c1; cf[2] = c2; cf[3] = c3;
    end
  endtask

  task automatic send_byte(logic [7:0] d, logic s, logic l);
    in_valid = 1'b1;
    in_data  = d;
    in_sor   = s;
    in_eor   = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sor   = 1'b0;
    in_eor   = 1'b0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() > 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(req, exp_q.size() == 0, "missing output bytes", exp_q.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  // mode 0 random, 1 all 255, 2 even bytes 10 / odd bytes 200
  task automatic run_block(string req, int wd, int ht, int mode, bit mid_cfg);
    int n = 2 * wd + 6;
    cur_req = req;
    cmd_wd = 8'(wd);
    cmd_ht = 8'(ht);
    cmd_go = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0;
    check("R6", busy === 1'b1, "busy after command", int'(busy), 1);
    if (mid_cfg) begin
      load_cfg(cf[3] + 7, -cf[2], 3, cf[0] + 11, 1'b0);
    end
    for (int r = 0; r < ht; r++) begin
      logic [7:0] rowb[] = new[n];
      for (int k = 0; k < n; k++) begin
        case (mode)
          1:       rowb[k] = 8'd255;
          2:       rowb[k] = (k % 2 == 0) ? 8'd10 : 8'd200;
          default: rowb[k] = 8'($urandom);
        endcase
      end
      for (int j = 0; j < 2 * wd; j++) begin
        exp_t x;
        x.d = 8'(model(rowb[j], rowb[j+2], rowb[j+4], rowb[j+6]));
        x.m = {j == 0, j == 2 * wd - 1, (j == 2 * wd - 1) && (r == ht - 1)};
        exp_q.push_back(x);
      end
      for (int k = 0; k < n; k++) begin
        send_byte(rowb[k], k == 0, k == n - 1);
        if (k == n - 2 && r == ht - 1) begin
          check("R6", busy === 1'b1, "busy before final byte", int'(busy), 1);
        end
      end
    end
    check("R6", busy === 1'b0, "busy after final byte", int'(busy), 0);
    drain(req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10", busy === 1'b0, "busy after reset", int'(busy), 0);
    check("R10", in_ready === 1'b0, "in_ready after reset", int'(in_ready), 0);
    check("R10", out_valid === 1'b0, "out_valid after reset", int'(out_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_arith;      // R3 typical weights, random rows
    load_cfg(-2, 58, 10, -2, 1'b1);
    run_block("R3", 4, 2, 0, 1'b0);
    load_cfg(-6, 46, 28, -4, 1'b1);
    run_block("R3", 8, 1, 0, 1'b0);
  endtask

  task automatic t_interleave; // R1 components stay apart: expect 10 / 200
    load_cfg(0, 32, 32, 0, 1'b1);
    run_block("R1", 4, 1, 2, 1'b0);
    load_cfg(-32, 64, 64, -32, 1'b1);
    run_block("R1", 6, 1, 2, 1'b0);
  endtask

  task automatic t_clamp;      // R4 saturate high: 255 rows with +64/+64
    load_cfg(0, 64, 64, 0, 1'b1);
    run_block("R4", 4, 1, 1, 1'b0);
    load_cfg(-128, 127, 127, -128, 1'b1);
    run_block("R4", 4, 1, 0, 1'b0);
  endtask

  task automatic t_sign;       // R2 positive tap0/tap3 still subtract -> 0
    load_cfg(64, 0, 0, -64, 1'b1);
    run_block("R2", 4, 1, 1, 1'b0);
    load_cfg(0, -64, -64, 0, 1'b1);   // negative middle taps still add -> 255
    run_block("R2", 4, 1, 1, 1'b0);
  endtask

  task automatic t_rows;       // R5 framing over narrow and wide rows
    load_cfg(int'($signed(8'($urandom))), 40, 30, -5, 1'b1);
    run_block("R5", 2, 4, 0, 1'b0);
    run_block("R5", 10, 3, 0, 1'b0);
  endtask

  task automatic t_zero;       // R7 height zero
    cur_req = "R7";
    cmd_wd = 8'd4;
    cmd_ht = 8'd0;
    cmd_go = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R7", busy === 1'b0 && in_ready === 1'b0, "busy/in_ready idle",
            int'({busy, in_ready}), 0);
      check("R7", out_valid === 1'b0, "no output", int'(out_valid), 0);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_cfg_busy;   // R8 load while busy is ignored
    load_cfg(1, 60, 5, 0, 1'b1);
    run_block("R8", 4, 2, 0, 1'b1);
    run_block("R8", 4, 1, 0, 1'b0);
  endtask

  task automatic t_stall;      // R9 random back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      load_cfg(int'($signed(8'($urandom))), int'($signed(8'($urandom))),
               int'($signed(8'($urandom))), int'($signed(8'($urandom))), 1'b1);
      run_block("R9", 8, 3, 0, 1'b0);
    end
    stall_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check("R6", 1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_arith();
    t_interleave();
    t_clamp();
    t_sign();
    t_rows();
    t_zero();
    t_cfg_busy();
    t_stall();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule